// File: doc/BRIEF.md
# Processor NMI and INIT# Sideband Controller

This block drives the processor's non-maskable interrupt line and its INIT# line from inside a PC-style I/O controller. It runs on the PCI clock. NMI collects five hardware error sources and one software trigger. Each source is latched into a sticky status bit on its rising edge. NMI is requested whenever a latched bit is set and the NMI gate bit is open. The gate bit lives behind I/O port 70h, bit 7. Software clears the latched bits with a write-one-to-clear port.

INIT# comes from the keyboard controller's reset request, which is asynchronous and active low. The request is synchronised, and a falling edge starts an INIT# pulse of a fixed length. A falling edge that is detected while a sleep-state entry is in progress is discarded. Both pins are open drain with external pull-ups, so the block drives only a drive-enable for each.

Top module: `nmi_init_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all status bits, the NMI gate and any INIT# pulse are cleared. After that edge `nmi_sts_o` is 0, `nmi_oe_o` is 0 and `init_oe_o` is 0.
- R2: A rising edge on `hw_err_i[i]`, sampled at clock edge k, sets `nmi_sts_o[i]` after edge k. The bit indices are: 0 = LPC bus error, 1 = LPC transaction timeout, 2 = SERR#, 3 = PERR#, 4 = IOCHK# from the serial IRQ stream. A source that stays high does not set its bit again.
- R3: A status bit stays set until a cycle with `sts_clr_wr_i` high and the matching bit of `sts_clr_mask_i` at 1. That cycle clears the bit after the edge. Mask bits at 0 leave their status bits unchanged.
- R4: `nmi_oe_o` is high exactly when the gate is 1 and at least one status bit is set. With the gate at 0, no source can raise NMI, but the sources are still latched.
- R5: A cycle with `gate_wr_i` high loads `gate_wdata_i` into the gate after the edge. The gate is active high, and 1 enables NMI.
- R6: Writing `sw_nmi_wr_i`=1 with `sw_nmi_wdata_i`=1 at edge k sets status bit 5 after edge k+1. The trigger bit then clears itself, so a later write raises bit 5 again once it has been cleared. A write with data 0 has no effect.
- R7: If a source edge and a clear of the same bit fall in one cycle, the bit ends up set.
- R8: If `kbd_rst_n_i` is first sampled low at edge k after being high, `init_oe_o` goes high after edge k+2. It stays high for exactly 16 clock cycles.
- R9: A new falling edge that is detected while a pulse is active restarts the pulse at its full length of 16 cycles.
- R10: A falling edge is ignored if `sleep_entry_i` is high in the cycle in which the edge is detected, which is the cycle before the pulse would start.
- R11: Holding `kbd_rst_n_i` low, or a rising edge on it, starts no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_wr_i | input | 1 | Write strobe for the NMI gate (port 70h bit 7) |
| gate_wdata_i | input | 1 | Gate value to write, 1 = enabled |
| sw_nmi_wr_i | input | 1 | Write strobe for the software NMI trigger |
| sw_nmi_wdata_i | input | 1 | Trigger value, 1 raises NMI |
| sts_clr_wr_i | input | 1 | Write strobe for status clear |
| sts_clr_mask_i | input | 6 | Write-one-to-clear mask, bit 5 = software |
| hw_err_i | input | 5 | Hardware error sources, synchronous to clk |
| kbd_rst_n_i | input | 1 | Asynchronous keyboard-controller reset request, active low |
| sleep_entry_i | input | 1 | High while the system is entering S3, S4 or S5 |
| nmi_sts_o | output | 6 | Latched NMI status bits |
| nmi_oe_o | output | 1 | Drive-enable that asserts NMI toward the processor |
| init_oe_o | output | 1 | Drive-enable that pulls INIT# low |

## Verification
If a status flip-flop is wrong, it appears on `nmi_sts_o` after one edge, and on `nmi_oe_o` in the same cycle whenever the gate is open. A wrong pulse counter or synchroniser stage shows as an INIT# pulse that starts a cycle early or late, or that is one cycle short or long. It can also show as a pulse that is not restarted or not blocked. All of these appear within about 20 cycles of the falling edge. The bench compares every output in every cycle against an arithmetic model, so the first wrong cycle is reported.

// File: rtl/nmi_init_pkg.sv
package nmi_init_pkg;
   // Bit positions of the latched NMI causes; the order is visible on nmi_sts_o.
   typedef enum int unsigned {
      SRC_LPC_ERR  = 0,
      SRC_LPC_TMO  = 1,
      SRC_SERR     = 2,
      SRC_PERR     = 3,
      SRC_IOCHK    = 4
   } hw_src_e;

   localparam int unsigned DEF_HW_SRCS   = 5;
   localparam int unsigned DEF_PULSE     = 16;
   localparam int unsigned DEF_SYNC_STGS = 2;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/nmi_kbd_sync.sv
module nmi_kbd_sync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic edge_o
);
   localparam logic IDLE = ACTIVE_LOW ? 1'b1 : 1'b0;

   if (STAGES < 2) begin : g_bad_stages
      $error("nmi_kbd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE}};
         last_q  <= IDLE;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   if (ACTIVE_LOW) begin : g_fall
      assign edge_o = last_q & ~chain_q[STAGES-1];
   end else begin : g_rise
      assign edge_o = ~last_q & chain_q[STAGES-1];
   end

   // R11: one detected edge is never followed by another in the next cycle
   a_r11_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/nmi_status_bank.sv
module nmi_status_bank #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] sts_o,
   output logic         any_o
);
   if (N < 1) begin : g_bad_n
      $error("nmi_status_bank: N must be at least 1");
   end

   logic [N-1:0] prev_q;
   logic [N-1:0] sts_q;

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            sts_q[g]  <= 1'b0;
         end else begin
            prev_q[g] <= src_i[g];
            if (src_i[g] && !prev_q[g]) begin
               sts_q[g] <= 1'b1;
            end else if (clr_i[g]) begin
               sts_q[g] <= 1'b0;
            end
         end
      end

      a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i[g] && !prev_q[g]) |=> sts_q[g]);
      a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_q[g] && !clr_i[g]) |=> sts_q[g]);
      a_r3_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !src_i[g]) |=> !sts_q[g]);
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && src_i[g] && !prev_q[g]) |=> sts_q[g]);
   end

   assign sts_o = sts_q;
   assign any_o = |sts_q;
endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer #(
   parameter int unsigned PULSE_CLKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic block_i,
   output logic active_o
);
   import nmi_init_pkg::*;

   if (PULSE_CLKS < 1) begin : g_bad_pulse
      $error("init_pulse_timer: PULSE_CLKS must be at least 1");
   end

   localparam int unsigned   CW   = cnt_width(PULSE_CLKS);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CLKS);

   logic [CW-1:0] cnt_q;
   logic          load;

   assign load = start_i & ~block_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);

   a_r9_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == LOAD));
   a_r8_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
   a_r10_blocked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !(start_i && !block_i)) |=> !active_o);
endmodule

// File: rtl/nmi_init_ctrl.sv
module nmi_init_ctrl #(
   parameter int unsigned NUM_HW_SRC      = nmi_init_pkg::DEF_HW_SRCS,
   parameter int unsigned INIT_PULSE_CLKS = nmi_init_pkg::DEF_PULSE,
   parameter int unsigned KBD_SYNC_STAGES = nmi_init_pkg::DEF_SYNC_STGS,
   parameter bit          GATE_RESET      = 1'b0,
   localparam int unsigned NUM_SRC        = NUM_HW_SRC + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  gate_wr_i,
   input  logic                  gate_wdata_i,
   input  logic                  sw_nmi_wr_i,
   input  logic                  sw_nmi_wdata_i,
   input  logic                  sts_clr_wr_i,
   input  logic [NUM_SRC-1:0]    sts_clr_mask_i,
   input  logic [NUM_HW_SRC-1:0] hw_err_i,
   input  logic                  kbd_rst_n_i,
   input  logic                  sleep_entry_i,
   output logic [NUM_SRC-1:0]    nmi_sts_o,
   output logic                  nmi_oe_o,
   output logic                  init_oe_o
);
   if (NUM_HW_SRC < 1 || NUM_HW_SRC > 31) begin : g_bad_src
      $error("nmi_init_ctrl: NUM_HW_SRC out of range");
   end

   logic               gate_q;
   logic               sw_trig_q;
   logic [NUM_SRC-1:0] src_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic               any_sts;
   logic               kbd_edge;

   // Gate and self-clearing software trigger
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q    <= GATE_RESET;
         sw_trig_q <= 1'b0;
      end else begin
         if (gate_wr_i) gate_q <= gate_wdata_i;
         sw_trig_q <= sw_nmi_wr_i & sw_nmi_wdata_i;
      end
   end

   assign src_vec = {sw_trig_q, hw_err_i};
   assign clr_vec = sts_clr_wr_i ? sts_clr_mask_i : '0;

   nmi_status_bank #(.N(NUM_SRC)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (src_vec),
      .clr_i (clr_vec),
      .sts_o (nmi_sts_o),
      .any_o (any_sts)
   );

   assign nmi_oe_o = gate_q & any_sts;

   nmi_kbd_sync #(.STAGES(KBD_SYNC_STAGES), .ACTIVE_LOW(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (kbd_rst_n_i),
      .edge_o  (kbd_edge)
   );

   init_pulse_timer #(.PULSE_CLKS(INIT_PULSE_CLKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (kbd_edge),
      .block_i  (sleep_entry_i),
      .active_o (init_oe_o)
   );

   a_r5_gate_load: assert property (@(posedge clk) disable iff (!rst_n)
      gate_wr_i |=> (gate_q == $past(gate_wdata_i)));
   a_r6_trig_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_trig_q && !(sw_nmi_wr_i && sw_nmi_wdata_i)) |=> !sw_trig_q);
   a_r6_trig_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_trig_q && !$past(sw_trig_q)) |=> nmi_sts_o[NUM_SRC-1]);
   a_r4_nmi_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_oe_o |-> ($countones(nmi_sts_o) != 0));
endmodule

// File: tb/test_nmi_init_ctrl.sv
module test_nmi_init_ctrl;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, gate_wr, gate_d, sw_wr, sw_d, clr_wr, kbd_n, sleep;
   logic [5:0] clr_m, sts;
   logic [4:0] hw;
   logic       nmi_oe, init_oe;

   nmi_init_ctrl i_nmi_init_ctrl (
      .clk(clk), .rst_n(rst_n), .gate_wr_i(gate_wr), .gate_wdata_i(gate_d),
      .sw_nmi_wr_i(sw_wr), .sw_nmi_wdata_i(sw_d), .sts_clr_wr_i(clr_wr),
      .sts_clr_mask_i(clr_m), .hw_err_i(hw), .kbd_rst_n_i(kbd_n),
      .sleep_entry_i(sleep), .nmi_sts_o(sts), .nmi_oe_o(nmi_oe), .init_oe_o(init_oe)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // Reference model, advanced once per clock edge from the requirements
   logic       m_gate, m_trig;
   logic [5:0] m_prev, m_sts;
   logic [2:0] m_kh;   // kbd samples at edges n-1, n-2, n-3
   int         m_cnt;

   task automatic tick();
      logic       n_gate, n_trig;
      logic [5:0] n_prev, n_sts, src;
      logic [2:0] n_kh;
      int         n_cnt;
      if (!rst_n) begin
         n_gate = 0; n_trig = 0; n_prev = 0; n_sts = 0; n_kh = 3'b111; n_cnt = 0;
      end else begin
         src    = {m_trig, hw};
         n_sts  = (m_sts & ~(clr_wr ? clr_m : 6'b0)) | (src & ~m_prev);
         n_prev = src;
         n_trig = sw_wr & sw_d;
         n_gate = gate_wr ? gate_d : m_gate;
         if (m_kh[1] == 1'b0 && m_kh[2] == 1'b1 && !sleep) n_cnt = 16;
         else n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
         n_kh = {m_kh[1:0], kbd_n};
      end
      @(posedge clk); #1;
      m_gate = n_gate; m_trig = n_trig; m_prev = n_prev; m_sts = n_sts;
      m_kh = n_kh; m_cnt = n_cnt;
   endtask

   task automatic check_all(input string tag);
      logic e_nmi, e_init;
      e_nmi  = m_gate && (m_sts != 0);
      e_init = (m_cnt != 0);
      total++;
      if (sts !== m_sts || nmi_oe !== e_nmi || init_oe !== e_init) begin
         bad++;
         $display("FAIL %s: sts=%b nmi=%b init=%b expected sts=%b nmi=%b init=%b",
                  tag, sts, nmi_oe, init_oe, m_sts, e_nmi, e_init);
      end
   endtask

   task automatic step(input string tag);
      tick();
      check_all(tag);
   endtask

   task automatic quiet();
      gate_wr = 0; sw_wr = 0; sw_d = 0; clr_wr = 0; clr_m = 0;
   endtask

   task automatic clear_all(input string tag);
      clr_wr = 1; clr_m = 6'h3F; hw = 0; step(tag); quiet(); step(tag);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      m_gate = 0; m_trig = 0; m_prev = 0; m_sts = 0; m_kh = 3'b111; m_cnt = 0;
      rst_n = 0; hw = 5'h1F; kbd_n = 1; sleep = 0; quiet();
      // R1: reset with sources held high
      repeat (3) step("R1 reset state");
      hw = 0; rst_n = 1;

      // R4: gate closed, random sources and clears, sources still latch
      for (int i = 0; i < 300; i++) begin
         hw = 5'($urandom); clr_wr = ($urandom % 4) == 0; clr_m = 6'($urandom);
         step("R4 gate closed");
         if (nmi_oe !== 1'b0) begin
            total++; bad++; $display("FAIL R4: nmi=%b expected 0", nmi_oe);
         end
      end
      quiet(); clear_all("R3 clear all");

      // R5: open the gate
      gate_wr = 1; gate_d = 1; step("R5 gate write"); quiet();

      // R2: each hardware source alone, held high afterwards
      for (int b = 0; b < 5; b++) begin
         hw = 5'(1 << b); step("R2 single source");
         repeat (3) step("R2 held source no re-set");
         clear_all("R3 clear after single");
      end

      // R7: edge and clear of the same bit together
      clr_wr = 1; clr_m = 6'h04; hw = 5'h04; step("R7 set wins");
      quiet(); step("R7 set wins hold");
      // R3: partial clear leaves other bits
      hw = 5'h1B; step("R3 setup");
      clr_wr = 1; clr_m = 6'h09; step("R3 partial clear"); quiet();
      step("R3 sticky");
      clear_all("R3 clear all");

      // R6: software trigger, data 0 ignored, repeat after clear
      sw_wr = 1; sw_d = 0; step("R6 data zero"); quiet();
      repeat (2) step("R6 data zero no effect");
      for (int k = 0; k < 3; k++) begin
         sw_wr = 1; sw_d = 1; step("R6 sw write"); quiet();
         repeat (2) step("R6 sw status");
         clr_wr = 1; clr_m = 6'h20; step("R6 sw clear"); quiet(); step("R6 cleared");
      end

      // R5: close gate while a cause is pending, reopen
      hw = 5'h01; step("R5 cause pending");
      gate_wr = 1; gate_d = 0; step("R5 gate closed"); quiet();
      gate_wr = 1; gate_d = 1; step("R5 gate reopened"); quiet();
      clear_all("R3 clear all");

      // R2: full random sweep of the NMI side
      for (int i = 0; i < 3000; i++) begin
         hw = 5'($urandom); sw_wr = $urandom % 2; sw_d = $urandom % 2;
         clr_wr = ($urandom % 3) == 0; clr_m = 6'($urandom);
         gate_wr = ($urandom % 16) == 0; gate_d = $urandom % 2;
         step("R2 random sweep");
      end
      quiet(); hw = 0;

      // R8: clean keyboard pulse, length and start cycle
      kbd_n = 0;
      repeat (25) step("R8 pulse timing");
      // R11: held low, then rising edge, no new pulse
      repeat (10) step("R11 held low");
      kbd_n = 1;
      repeat (20) step("R11 rising edge");

      // R9: retrigger during an active pulse
      kbd_n = 0; repeat (8) step("R9 first pulse");
      kbd_n = 1; repeat (2) step("R9 release");
      kbd_n = 0; repeat (25) step("R9 restarted pulse");
      kbd_n = 1; repeat (4) step("R9 idle");

      // R10: falling edge during sleep entry
      sleep = 1; kbd_n = 0; repeat (20) step("R10 blocked");
      kbd_n = 1; repeat (4) step("R10 idle");
      sleep = 0;

      // R9/R10: random sweep of keyboard and sleep inputs
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 7 == 0) kbd_n = ~kbd_n;
         sleep = ($urandom % 5) == 0;
         step("R9 R10 kbd sweep");
      end

      // R1: reset aborts a pulse in progress
      sleep = 0; kbd_n = 1; repeat (4) step("R1 pre");
      kbd_n = 0; repeat (6) step("R1 pulse running");
      rst_n = 0; step("R1 reset mid pulse");
      rst_n = 1; repeat (20) step("R1 after reset");

      done = 1;
      summary();
      $finish;
   end
endmodule